// File: doc/BRIEF.md
# Microphone Amplifier Configuration Port (write-only two-wire slave)

This block is the control front end of a dual-microphone amplifier. It listens on a two-wire serial bus (a clock line and an open-drain data line) as a write-only slave. It answers one fixed 7-bit device address and accepts any number of single data bytes after it. Bit 7 of each data byte chooses the destination. When bit 7 is clear, the byte goes to the gain register, which holds a 4-bit preamp code and a 3-bit post-amp code. When bit 7 is set, the byte goes to the routing register, which holds per-microphone mute bits, per-microphone enable bits and a 2-bit combining mode. There is no sub-address byte.

Both bus lines pass through a two-flop synchroniser into a system clock that runs at least eight times the 400 kHz bus rate. The lines are then edge-detected. A protocol state machine has these states: `ST_IDLE`, `ST_ADDR` (shift address), `ST_ADDR_HOLD` (wait for the clock to fall after the eighth address bit), `ST_ADDR_ACK` (hold the line low for the ninth clock), `ST_DATA`, `ST_DATA_HOLD`, `ST_DATA_ACK` and `ST_SKIP` (stay silent until the next START or STOP).

Its transitions are:
- A START from any state goes to `ST_ADDR`. A STOP goes to `ST_IDLE`.
- After the eighth address bit the machine moves to `ST_ADDR_HOLD` if the byte matches, and to `ST_SKIP` if it does not.
- A falling clock edge moves the machine HOLD→ACK and ACK→`ST_DATA`.
- The eighth data bit writes the byte and moves the machine to `ST_DATA_HOLD`.
- A low chip-on input forces `ST_IDLE`.

The decoded register fields drive the analog gain stages and the microphone routing directly.

Top module: `mic_cfg_slave`

## Requirements
- R1: After reset every output field is zero and `bus_dat_oe` is low.
- R2: An address byte of 0xCE (address 1100111, write) is acknowledged. `bus_dat_oe` pulls the data line low for the whole high phase of the ninth clock, and the line is released after that clock falls.
- R3: Any other address byte, including the read form 0xCF, gets no acknowledge. The data line is never driven again until the next START, and data bytes in that transfer change no output.
- R4: Bits are sampled on rising clock edges, MSB first. A data byte with bit 7 = 0 is acknowledged. Its bits [3:0] appear on `pre_gain_code` (0 = 6 dB, 2 dB per step) and its bits [6:4] set the post-amp code.
- R5: `post_gain_step` equals the post-amp code for codes 0..3 (0 = 6 dB, 3 dB per step) and is 4 for every code from 4 to 7.
- R6: A data byte with bit 7 = 1 is acknowledged. Bit 0 mutes mic 1 and bit 1 mutes mic 2 (`mic_mute[0]`/`[1]`, 1 = muted). Bit 2 enables mic 1 and bit 3 enables mic 2 (`mic_on[0]`/`[1]`). Bits [5:4] drive `mic_mode`, where 00 = noise cancelling, 01 = mic 1 pass-through, 10 = mic 2 pass-through and 11 = both summed. Bit 6 has no effect.
- R7: Several data bytes may follow one address. Each byte is acknowledged and routed by its own bit 7, and the register it does not address keeps its value.
- R8: A START or STOP that arrives before the eighth bit of a byte abandons that byte, and no register changes. After a START in mid-byte, a fresh address is accepted.
- R9: While `chip_on` is low, both registers read as zero and the bus is ignored: there is no acknowledge and no write. Registers stay zero when `chip_on` returns high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the bus bit rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| chip_on | input | 1 | Low = shutdown: registers cleared, bus ignored |
| bus_clk_i | input | 1 | Serial bus clock line |
| bus_dat_i | input | 1 | Serial bus data line (as seen on the wire) |
| bus_dat_oe | output | 1 | 1 = pull the data line low (open-drain) |
| pre_gain_code | output | 4 | Preamp gain code, 0 = 6 dB, 2 dB steps |
| post_gain_step | output | 3 | Post-amp gain step, 0..4 (6..18 dB) |
| mic_mute | output | 2 | Per-microphone mute, bit 0 = mic 1 |
| mic_on | output | 2 | Per-microphone enable, bit 0 = mic 1 |
| mic_mode | output | 2 | Combining mode (see R6) |

## Verification
Two things can land on the same system clock: the register write strobe fired by the eighth rising clock edge of a data byte, and the shutdown clear from `chip_on` falling. The bench provokes this by dropping `chip_on` in the same system cycle in which it raises the bus clock for the eighth bit of a routing byte. It passes only if every field stays zero once the transfer is closed and power is restored, so the clear must beat the write. A second collision, a STOP or START placed mid-byte, is judged by checking that the fields are unchanged and that the next address still gets its acknowledge.

// File: rtl/mcfg_pkg.sv
package mcfg_pkg;

    localparam int BYTE_BITS = 8;
    localparam int CNT_W     = $clog2(BYTE_BITS);
    localparam int PRE_W     = 4;
    localparam int POST_W    = 3;
    localparam int POST_MAX  = 4;
    localparam int GAIN_REG_W  = PRE_W + POST_W;
    localparam int ROUTE_REG_W = 6;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_HOLD,
        ST_ADDR_ACK,
        ST_DATA,
        ST_DATA_HOLD,
        ST_DATA_ACK,
        ST_SKIP
    } bus_state_e;

    typedef enum logic [1:0] {
        MODE_CANCEL = 2'b00,
        MODE_PASS1  = 2'b01,
        MODE_PASS2  = 2'b10,
        MODE_SUM    = 2'b11
    } mic_mode_e;

endpackage

// File: rtl/mcfg_line_sync.sv
module mcfg_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_raw,
    input  logic sda_raw,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_evt,
    output logic stop_evt
);

    // bit 1 = clock line, bit 0 = data line; idle bus is high
    logic [1:0] chain [STAGES];
    logic [1:0] prev;

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[g] <= 2'b11;
                    else        chain[g] <= {scl_raw, sda_raw};
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[g] <= 2'b11;
                    else        chain[g] <= chain[g-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev <= 2'b11;
        else        prev <= chain[STAGES-1];
    end

    logic scl_now, sda_now, scl_old, sda_old;
    assign scl_now = chain[STAGES-1][1];
    assign sda_now = chain[STAGES-1][0];
    assign scl_old = prev[1];
    assign sda_old = prev[0];

    assign sda_lvl   = sda_now;
    assign scl_rise  = scl_now & ~scl_old;
    assign scl_fall  = ~scl_now & scl_old;
    assign start_evt = scl_now & scl_old & sda_old & ~sda_now;
    assign stop_evt  = scl_now & scl_old & ~sda_old & sda_now;

endmodule

// File: rtl/mcfg_bus_fsm.sv
module mcfg_bus_fsm
    import mcfg_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'b1100111
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       chip_on,
    input  logic       sda_lvl,
    input  logic       scl_rise,
    input  logic       scl_fall,
    input  logic       start_evt,
    input  logic       stop_evt,
    output logic       drive_low,
    output logic       wr_stb,
    output logic [7:0] wr_byte
);

    localparam logic [7:0]       ADDR_WR  = {DEV_ADDR, 1'b0};
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_BITS - 1);

    bus_state_e       state, nxt;
    logic [CNT_W-1:0] cnt, cnt_n;
    logic [6:0]       shf, shf_n;
    logic [7:0]       shf_in;

    assign shf_in  = {shf, sda_lvl};
    assign wr_byte = shf_in;

    always_comb begin
        nxt    = state;
        cnt_n  = cnt;
        shf_n  = shf;
        wr_stb = 1'b0;
        if (!chip_on) begin
            nxt   = ST_IDLE;
            cnt_n = '0;
        end else if (start_evt) begin
            nxt   = ST_ADDR;
            cnt_n = '0;
        end else if (stop_evt) begin
            nxt   = ST_IDLE;
            cnt_n = '0;
        end else begin
            unique case (state)
                ST_IDLE: ;
                ST_SKIP: ;
                ST_ADDR: begin
                    if (scl_rise) begin
                        shf_n = shf_in[6:0];
                        if (cnt == LAST_BIT) begin
                            cnt_n = '0;
                            nxt   = (shf_in == ADDR_WR) ? ST_ADDR_HOLD : ST_SKIP;
                        end else begin
                            cnt_n = cnt + 1'b1;
                        end
                    end
                end
                ST_ADDR_HOLD: if (scl_fall) nxt = ST_ADDR_ACK;
                ST_ADDR_ACK: begin
                    if (scl_fall) begin
                        nxt   = ST_DATA;
                        cnt_n = '0;
                    end
                end
                ST_DATA: begin
                    if (scl_rise) begin
                        shf_n = shf_in[6:0];
                        if (cnt == LAST_BIT) begin
                            cnt_n  = '0;
                            wr_stb = 1'b1;
                            nxt    = ST_DATA_HOLD;
                        end else begin
                            cnt_n = cnt + 1'b1;
                        end
                    end
                end
                ST_DATA_HOLD: if (scl_fall) nxt = ST_DATA_ACK;
                ST_DATA_ACK: begin
                    if (scl_fall) begin
                        nxt   = ST_DATA;
                        cnt_n = '0;
                    end
                end
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
            shf   <= '0;
        end else begin
            state <= nxt;
            cnt   <= cnt_n;
            shf   <= shf_n;
        end
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) drive_low <= 1'b0;
        else        drive_low <= (nxt == ST_ADDR_ACK) || (nxt == ST_DATA_ACK);
    end

    // R2: acknowledge begins only after the bus clock has fallen
    p_ack_edge_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(drive_low) |-> $past(scl_fall));

    // R9: shutdown releases the line on the next cycle
    p_off_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !chip_on |=> !drive_low);

    // R3: a rejected transfer never drives the line
    p_skip_silent_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SKIP) |=> !drive_low);

endmodule

// File: rtl/mcfg_regfile.sv
module mcfg_regfile
    import mcfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              chip_on,
    input  logic              wr_stb,
    input  logic [7:0]        wr_byte,
    output logic [PRE_W-1:0]  pre_gain_code,
    output logic [POST_W-1:0] post_gain_step,
    output logic [1:0]        mic_mute,
    output logic [1:0]        mic_on,
    output logic [1:0]        mic_mode
);

    localparam logic [POST_W-1:0] STEP_CAP = POST_W'(POST_MAX);

    logic [GAIN_REG_W-1:0]  gain_q;
    logic [ROUTE_REG_W-1:0] route_q;
    logic [POST_W-1:0]      post_code;
    mic_mode_e              mode_dec;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gain_q  <= '0;
            route_q <= '0;
        end else if (!chip_on) begin
            gain_q  <= '0;
            route_q <= '0;
        end else if (wr_stb) begin
            if (wr_byte[7]) route_q <= wr_byte[ROUTE_REG_W-1:0];
            else            gain_q  <= wr_byte[GAIN_REG_W-1:0];
        end
    end

    assign post_code = gain_q[GAIN_REG_W-1:PRE_W];

    always_comb begin
        pre_gain_code  = gain_q[PRE_W-1:0];
        post_gain_step = (post_code >= STEP_CAP) ? STEP_CAP : post_code;
        mic_mute       = route_q[1:0];
        mic_on         = route_q[3:2];
        mode_dec       = mic_mode_e'(route_q[5:4]);
        mic_mode       = mode_dec;
    end

    // R5: decoded post step never exceeds the cap
    p_post_clamp_r5: assert property (@(posedge clk) disable iff (!rst_n)
        post_gain_step <= STEP_CAP);

    // R9: shutdown clears both registers
    p_off_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !chip_on |=> (pre_gain_code == '0 && post_gain_step == '0 &&
                      mic_mute == '0 && mic_on == '0 && mic_mode == '0));

    // R7: fields hold when no byte is written
    p_hold_no_wr_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (chip_on && !wr_stb) |=> ($stable(pre_gain_code) && $stable(post_gain_step) &&
                                  $stable(mic_mute) && $stable(mic_on) && $stable(mic_mode)));

endmodule

// File: rtl/mic_cfg_slave.sv
module mic_cfg_slave
    import mcfg_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR    = 7'b1100111,
    parameter int         SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              chip_on,
    input  logic              bus_clk_i,
    input  logic              bus_dat_i,
    output logic              bus_dat_oe,
    output logic [PRE_W-1:0]  pre_gain_code,
    output logic [POST_W-1:0] post_gain_step,
    output logic [1:0]        mic_mute,
    output logic [1:0]        mic_on,
    output logic [1:0]        mic_mode
);

    logic       sda_lvl, scl_rise, scl_fall, start_evt, stop_evt;
    logic       wr_stb;
    logic [7:0] wr_byte;

    mcfg_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_raw   (bus_clk_i),
        .sda_raw   (bus_dat_i),
        .sda_lvl   (sda_lvl),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_evt (start_evt),
        .stop_evt  (stop_evt)
    );

    mcfg_bus_fsm #(.DEV_ADDR(DEV_ADDR)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .chip_on   (chip_on),
        .sda_lvl   (sda_lvl),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_evt (start_evt),
        .stop_evt  (stop_evt),
        .drive_low (bus_dat_oe),
        .wr_stb    (wr_stb),
        .wr_byte   (wr_byte)
    );

    mcfg_regfile u_regs (
        .clk            (clk),
        .rst_n          (rst_n),
        .chip_on        (chip_on),
        .wr_stb         (wr_stb),
        .wr_byte        (wr_byte),
        .pre_gain_code  (pre_gain_code),
        .post_gain_step (post_gain_step),
        .mic_mute       (mic_mute),
        .mic_on         (mic_on),
        .mic_mode       (mic_mode)
    );

endmodule

// File: tb/mic_cfg_slave_bench.sv
module mic_cfg_slave_bench;

    localparam int Q = 10; // system cycles per quarter of a bus bit

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic chip_on = 1'b1;
    logic m_scl = 1'b1;
    logic m_low = 1'b0;
    logic bus_sda;
    logic dut_oe;
    logic [3:0] pre_gain_code;
    logic [2:0] post_gain_step;
    logic [1:0] mic_mute, mic_on, mic_mode;

    always #10 clk = ~clk; // 50 MHz

    assign bus_sda = !(m_low || dut_oe);

    mic_cfg_slave u_mic_cfg_slave (
        .clk            (clk),
        .rst_n          (rst_n),
        .chip_on        (chip_on),
        .bus_clk_i      (m_scl),
        .bus_dat_i      (bus_sda),
        .bus_dat_oe     (dut_oe),
        .pre_gain_code  (pre_gain_code),
        .post_gain_step (post_gain_step),
        .mic_mute       (mic_mute),
        .mic_on         (mic_on),
        .mic_mode       (mic_mode)
    );

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // model registers
    logic [6:0] m_gain = '0;
    logic [5:0] m_route = '0;

    typedef struct { string req; int exp; } item_t;
    item_t ack_q[$];
    item_t fld_q[$];
    int    ack_act;
    event  ack_ev, fld_ev;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int fields_now();
        return {pre_gain_code, post_gain_step, mic_mute, mic_on, mic_mode};
    endfunction

    function automatic int fields_model();
        logic [2:0] st;
        st = (m_gain[6:4] >= 3'd4) ? 3'd4 : m_gain[6:4];
        return {m_gain[3:0], st, m_route[1:0], m_route[3:2], m_route[5:4]};
    endfunction

    // monitors: pop expected items and compare
    always @(ack_ev) begin
        item_t it;
        it = ack_q.pop_front();
        chk(ack_act == it.exp, it.req, ack_act, it.exp);
    end

    always @(fld_ev) begin
        item_t it;
        it = fld_q.pop_front();
        chk(fields_now() == it.exp, it.req, fields_now(), it.exp);
    end

    task automatic wq(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        m_scl = 1'b0; wq(Q);
        m_low = 1'b0; wq(Q);
        m_scl = 1'b1; wq(Q);
        m_low = 1'b1; wq(Q);
        m_scl = 1'b0; wq(Q);
    endtask

    task automatic bus_stop();
        m_scl = 1'b0;
        m_low = 1'b1; wq(Q);
        m_scl = 1'b1; wq(Q);
        m_low = 1'b0; wq(2*Q);
    endtask

    task automatic bus_bit(input logic b);
        m_low = !b; wq(Q);
        m_scl = 1'b1; wq(2*Q);
        m_scl = 1'b0; wq(Q);
    endtask

    // sends one byte and queues the expected acknowledge
    task automatic send_byte(input logic [7:0] v, input bit exp_ack, input string req);
        item_t it;
        for (int i = 7; i >= 0; i--) bus_bit(v[i]);
        m_low = 1'b0; wq(Q);
        m_scl = 1'b1; wq(Q);
        it.req = req; it.exp = exp_ack;
        ack_q.push_back(it);
        ack_act = (bus_sda == 1'b0);
        -> ack_ev;
        wq(Q);
        m_scl = 1'b0; wq(Q);
    endtask

    task automatic model_write(input logic [7:0] v);
        if (v[7]) m_route = v[5:0];
        else      m_gain  = v[6:0];
    endtask

    task automatic expect_fields(input string req);
        item_t it;
        wq(8);
        it.req = req; it.exp = fields_model();
        fld_q.push_back(it);
        -> fld_ev;
        wq(2);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; errors++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        wq(5);
        rst_n = 1'b1;
        wq(5);
        // R1: reset state
        chk(fields_now() == 0, "R1 reset fields", fields_now(), 0);
        chk(dut_oe == 1'b0, "R1 reset line released", dut_oe, 0);

        // R2 + R4: address ack, gain byte
        bus_start();
        send_byte(8'hCE, 1, "R2 address ack");
        chk(dut_oe == 1'b0, "R2 line released after ack", dut_oe, 0);
        send_byte(8'h35, 1, "R4 gain byte ack");
        model_write(8'h35);
        bus_stop();
        expect_fields("R4 gain fields 0x35");

        // R5: clamp for codes 4..7, and code 3 unclamped
        for (int c = 3; c < 8; c++) begin
            logic [7:0] v;
            v = {1'b0, 3'(c), 4'hA};
            bus_start();
            send_byte(8'hCE, 1, "R5 address ack");
            send_byte(v, 1, "R5 gain ack");
            model_write(v);
            bus_stop();
            expect_fields("R5 post step clamp");
        end

        // R6: all modes, bit 6 ignored
        for (int md = 0; md < 4; md++) begin
            logic [7:0] v;
            v = {1'b1, 1'b1, 2'(md), 2'(md ^ 1), 2'(3 - md)};
            bus_start();
            send_byte(8'hCE, 1, "R6 address ack");
            send_byte(v, 1, "R6 routing ack");
            model_write(v);
            bus_stop();
            expect_fields("R6 routing fields");
        end

        // R7: several bytes after one address
        bus_start();
        send_byte(8'hCE, 1, "R7 address ack");
        send_byte(8'h0F, 1, "R7 byte1 ack"); model_write(8'h0F);
        send_byte(8'h96, 1, "R7 byte2 ack"); model_write(8'h96);
        send_byte(8'h21, 1, "R7 byte3 ack"); model_write(8'h21);
        bus_stop();
        expect_fields("R7 multi byte routing");

        // R3: read address, wrong address
        bus_start();
        send_byte(8'hCF, 0, "R3 read address not acked");
        send_byte(8'h7F, 0, "R3 data after read not acked");
        bus_stop();
        expect_fields("R3 no change after read");
        bus_start();
        send_byte(8'h90, 0, "R3 wrong address not acked");
        send_byte(8'hBF, 0, "R3 data after wrong address");
        bus_stop();
        expect_fields("R3 no change after wrong address");

        // R8: STOP mid-byte
        bus_start();
        send_byte(8'hCE, 1, "R8 address ack");
        bus_bit(1'b0); bus_bit(1'b1); bus_bit(1'b1); bus_bit(1'b1);
        bus_stop();
        expect_fields("R8 stop mid byte no write");
        // R8: START mid-byte then new transfer
        bus_start();
        send_byte(8'hCE, 1, "R8 address ack 2");
        bus_bit(1'b1); bus_bit(1'b0); bus_bit(1'b1);
        bus_start();
        send_byte(8'hCE, 1, "R8 restart address ack");
        send_byte(8'h44, 1, "R8 restart data ack");
        model_write(8'h44);
        bus_stop();
        expect_fields("R8 restart write");

        // R9: shutdown clears and ignores bus
        chip_on = 1'b0;
        m_gain = '0; m_route = '0;
        expect_fields("R9 shutdown clears");
        bus_start();
        send_byte(8'hCE, 0, "R9 no ack when off");
        send_byte(8'h13, 0, "R9 no data ack when off");
        bus_stop();
        expect_fields("R9 no write when off");
        chip_on = 1'b1;
        expect_fields("R9 stays clear after power on");

        // R9 collision: shutdown on the eighth rising edge of a routing byte
        bus_start();
        send_byte(8'hCE, 1, "R9 collision address ack");
        begin
            logic [7:0] v;
            v = 8'hBF;
            for (int i = 7; i >= 1; i--) bus_bit(v[i]);
            m_low = !v[0]; wq(Q);
            m_scl = 1'b1; chip_on = 1'b0; wq(2*Q);
            m_scl = 1'b0; wq(Q);
        end
        bus_stop();
        chip_on = 1'b1;
        expect_fields("R9 clear beats write");
        chk(dut_oe == 1'b0, "R9 line released", dut_oe, 0);

        wq(20);
        if (!done) begin
            done = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule